// File: doc/BRIEF.md
# ECC Decoder Self-Test Controller

This block checks the single-correct, double-detect decoder of a 64-bit memory word without touching the memory array. Software first unlocks a test mode by writing a key to the control register. It then loads two 32-bit operand words and an 8-bit syndrome, and starts a run. The controller takes a snapshot of these operands into the decoder and waits a fixed number of cycles. It then stores what the decoder produced in five 32-bit result registers and raises a done flag, which software polls.

The decoder treats the syndrome as inverted, so an all-ones syndrome means "no error". An erased word, which is all ones in both the data and the check byte, therefore reads as clean. Each data bit has its own 8-bit column code. An inverted syndrome that matches a column flips that data bit. An inverted syndrome with weight one points at a check bit. Any other non-zero pattern is reported as uncorrectable.

Registers are reached through a simple word-addressed bus. Write data is taken on the clock edge where the write strobe is high. Read data appears on the output one cycle after the read strobe and holds until the next read.

Top module: `eccst_top`

## Requirements
- R1: After reset, every register reads as zero, including the control register, both operand registers and all result registers.
- R2: While bit 31 of the control register (offset 0) is 0, the block ignores every write except the key 0xF9F99999 to offset 0. That key sets bit 31 and leaves every other control field at 0. Writes to the operand registers are also ignored in this state.
- R3: The control register has this layout: bit 31 is the test enable, bits 23:16 are the injected syndrome, bit 3 is the check select, bit 1 is the start bit and bit 0 is the done flag. Every other bit reads 0. While enabled, a write with bit 31 set updates the syndrome, select and start fields.
- R4: While enabled, a control write with bit 31 clear leaves test mode and clears every control field, including the done flag.
- R5: A run starts on a control write that changes the start bit from 0 to 1 and has bit 3 set in the same write. The run uses the operand words (offset 1 holds data bits 31:0, offset 2 holds bits 63:32) and the syndrome value of that start write. The done flag rises RUN_CYCLES clock edges after the start edge. Operand writes made after the start do not change the result of that run.
- R6: Writing the start bit as 0 clears the done flag and cancels a run that is in progress without capturing anything. A new start clears the done flag. Writing the start bit as 1 while it is already 1 does not begin a new run.
- R7: An injected syndrome of 0xFF is decoded as error-free. Both corrected words equal the input and both status flags are 0.
- R8: Let s be the inverted injected syndrome. The column code of data bit i (0 to 63) is the i-th value, in increasing numeric order, among the 8-bit values of odd weight 3 or more. If s equals the column of bit i, that bit is flipped in the corrected word and the correctable flag is set. If s has weight 1, the data passes through unchanged and the correctable flag is set.
- R9: Any other non-zero s leaves the data unchanged, sets the uncorrectable flag and clears the correctable flag.
- R10: The result registers are mapped as follows. Offset 3 holds corrected bits 31:0 and offset 4 holds corrected bits 63:32. Offset 5 holds the raw input bits 31:0 and offset 6 holds the raw input bits 63:32. Offset 7 holds {7'b0, uncorrectable, syndrome, 7'b0, correctable, syndrome}. With operands 0x55555555 and 0xAAAAAAAA and syndrome 0xFF, the five registers read 0x55555555, 0xAAAAAAAA, 0x55555555, 0xAAAAAAAA and 0x00FF00FF.
- R11: The result registers change only when a run completes. A cancelled run and leaving test mode leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |

## Verification
Most decoder paths can only be reached by injecting a crafted syndrome. The bench therefore runs all 256 syndrome values over several operand patterns, which covers the clean case, every data column, every check-bit position and the uncorrectable codes. For each run it predicts the corrected word and the flags from its own column table. The timing windows are the other hard part. A cancel has to land while the run counter is still going, and an operand write has to land after the snapshot but before capture. The bench places these writes a known number of edges after the start write, then confirms through readback that the results were held or unchanged.

// File: rtl/eccst_pkg.sv
package eccst_pkg;
  localparam int WORD_W = 32;
  localparam int DATA_W = 2 * WORD_W;
  localparam int SYN_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_DLO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DHI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FHI  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RLO  = 3'd5;
  localparam logic [ADDR_W-1:0] A_RHI  = 3'd6;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd7;

  localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'hF9F9_9999;

  localparam int B_EN     = 31;
  localparam int B_SYN_LO = 16;
  localparam int B_SEL    = 3;
  localparam int B_GO     = 1;
  localparam int B_DONE   = 0;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [SYN_W-1:0]  syn;
  } eccst_operand_t;

  typedef struct packed {
    logic [DATA_W-1:0] fixed;
    logic [DATA_W-1:0] raw;
    logic [SYN_W-1:0]  syn;
    logic              sec;
    logic              ded;
  } eccst_result_t;

  // i-th odd-weight (>=3) code value in increasing order
  function automatic logic [SYN_W-1:0] col_code(input int idx);
    int n;
    logic [SYN_W-1:0] r;
    logic [SYN_W-1:0] v;
    n = 0;
    r = '0;
    for (int k = 0; k < (1 << SYN_W); k++) begin
      v = SYN_W'(k);
      if (($countones(v) % 2 == 1) && ($countones(v) >= 3)) begin
        if (n == idx) r = v;
        n++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/eccst_dec.sv
module eccst_dec
  import eccst_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  eccst_operand_t op_in,
  output eccst_result_t  res_out
);
  eccst_operand_t    op_q;
  logic [SYN_W-1:0]  s;
  logic [DATA_W-1:0] hit;
  logic              data_err;
  logic              chk_err;

  always_ff @(posedge clk) begin
    if (rst)       op_q <= '0;
    else if (load) op_q <= op_in;
  end

  assign s = ~op_q.syn;

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [SYN_W-1:0] COL = col_code(i);
    assign hit[i] = (s == COL);
  end

  always_comb begin
    data_err = |hit;
    chk_err  = ($countones(s) == 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out <= '0;
    end else begin
      res_out.fixed <= op_q.data ^ hit;
      res_out.raw   <= op_q.data;
      res_out.syn   <= op_q.syn;
      res_out.sec   <= data_err | chk_err;
      res_out.ded   <= (s != '0) && !data_err && !chk_err;
    end
  end

  // R7
  clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (op_q.syn == '1) |=> (res_out.fixed == $past(op_q.data) && !res_out.sec && !res_out.ded));

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_out.sec && res_out.ded));

  // R8
  one_flip_chk: assert property (@(posedge clk) disable iff (rst)
    res_out.sec |-> ($countones(res_out.fixed ^ res_out.raw) <= 1));
endmodule

// File: rtl/eccst_ctrl.sv
module eccst_ctrl
  import eccst_pkg::*;
#(
  parameter int RUN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic              en_o,
  output logic [SYN_W-1:0]  syn_o,
  output logic              sel_o,
  output logic              go_o,
  output logic              done_o,
  output logic [WORD_W-1:0] dlo_o,
  output logic [WORD_W-1:0] dhi_o,
  output logic              load_o,
  output logic              cap_o,
  output eccst_operand_t    op_o
);
  localparam int RUN_EFF = (RUN_CYCLES < 2) ? 2 : RUN_CYCLES;
  localparam int CNT_W   = $clog2(RUN_EFF + 1);

  logic              en_q, sel_q, go_q, done_q;
  logic [SYN_W-1:0]  syn_q;
  logic [WORD_W-1:0] dlo_q, dhi_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ctrl_wr, key_wr, go_req, kill, cap;

  always_comb begin
    ctrl_wr = wr && (addr == A_CTRL);
    key_wr  = ctrl_wr && (wdata == UNLOCK_KEY);
    go_req  = ctrl_wr && en_q && wdata[B_EN] && wdata[B_GO] && wdata[B_SEL] && !go_q;
    kill    = ctrl_wr && en_q && (!wdata[B_EN] || !wdata[B_GO]);
    cap     = (cnt_q == CNT_W'(1)) && !kill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; sel_q <= 1'b0; go_q <= 1'b0; done_q <= 1'b0;
      syn_q <= '0; cnt_q <= '0;
    end else begin
      if (!en_q) begin
        if (key_wr) en_q <= 1'b1;
      end else if (ctrl_wr) begin
        if (!wdata[B_EN]) begin
          en_q <= 1'b0; sel_q <= 1'b0; go_q <= 1'b0; syn_q <= '0;
        end else begin
          syn_q <= wdata[B_SYN_LO +: SYN_W];
          sel_q <= wdata[B_SEL];
          go_q  <= wdata[B_GO];
        end
      end
      if (go_req)                cnt_q <= CNT_W'(RUN_EFF);
      else if (kill)             cnt_q <= '0;
      else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
      if (go_req || kill)        done_q <= 1'b0;
      else if (cap)              done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dlo_q <= '0;
      dhi_q <= '0;
    end else if (wr && en_q) begin
      if (addr == A_DLO) dlo_q <= wdata;
      if (addr == A_DHI) dhi_q <= wdata;
    end
  end

  assign en_o   = en_q;
  assign syn_o  = syn_q;
  assign sel_o  = sel_q;
  assign go_o   = go_q;
  assign done_o = done_q;
  assign dlo_o  = dlo_q;
  assign dhi_o  = dhi_q;
  assign load_o = go_req;
  assign cap_o  = cap;
  assign op_o   = '{data: {dhi_q, dlo_q}, syn: wdata[B_SYN_LO +: SYN_W]};

  // R2
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !key_wr) |=> !en_q);

  // R4
  exit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && en_q && !wdata[B_EN]) |=> (!en_q && !go_q && !done_q && syn_q == '0));

  // R6
  start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
    go_req |=> !done_q);

  // R6
  done_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (go_q && en_q));
endmodule

// File: rtl/eccst_results.sv
module eccst_results
  import eccst_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  eccst_result_t res_in,
  output eccst_result_t res_q
);
  always_ff @(posedge clk) begin
    if (rst)      res_q <= '0;
    else if (cap) res_q <= res_in;
  end

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(res_q));
endmodule

// File: rtl/eccst_top.sv
module eccst_top
  import eccst_pkg::*;
#(
  parameter int RUN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);
  logic              en, sel, go, done, load, cap;
  logic [SYN_W-1:0]  syn;
  logic [WORD_W-1:0] dlo, dhi;
  eccst_operand_t    op;
  eccst_result_t     dec_res, res;
  logic [WORD_W-1:0] rd_mux;

  eccst_ctrl #(.RUN_CYCLES(RUN_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .en_o(en), .syn_o(syn), .sel_o(sel), .go_o(go), .done_o(done),
    .dlo_o(dlo), .dhi_o(dhi), .load_o(load), .cap_o(cap), .op_o(op)
  );

  eccst_dec u_dec (
    .clk(clk), .rst(rst), .load(load), .op_in(op), .res_out(dec_res)
  );

  eccst_results u_res (
    .clk(clk), .rst(rst), .cap(cap), .res_in(dec_res), .res_q(res)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL: rd_mux = {en, 7'b0, syn, 12'b0, sel, 1'b0, go, done};
      A_DLO:  rd_mux = dlo;
      A_DHI:  rd_mux = dhi;
      A_FLO:  rd_mux = res.fixed[WORD_W-1:0];
      A_FHI:  rd_mux = res.fixed[DATA_W-1:WORD_W];
      A_RLO:  rd_mux = res.raw[WORD_W-1:0];
      A_RHI:  rd_mux = res.raw[DATA_W-1:WORD_W];
      default: rd_mux = {7'b0, res.ded, res.syn, 7'b0, res.sec, res.syn};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: tb/sim_eccst_top.sv
`timescale 1ns/1ps
module sim_eccst_top;
  localparam int RUN = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] bcol [64];

  eccst_top #(.RUN_CYCLES(RUN)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2.5 clk = ~clk;

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  function automatic logic [159:0] expect_res(input logic [63:0] d, input logic [7:0] syn);
    logic [7:0] s;
    logic [63:0] f;
    logic sec, ded;
    s = ~syn; f = d; sec = 1'b0; ded = 1'b0;
    if (s != 8'h00) begin
      if ($countones(s) == 1) sec = 1'b1;
      else begin
        for (int i = 0; i < 64; i++) if (bcol[i] == s) begin f[i] = ~f[i]; sec = 1'b1; end
        if (!sec) ded = 1'b1;
      end
    end
    return {f[31:0], f[63:32], d[31:0], d[63:32], {7'b0, ded, syn, 7'b0, sec, syn}};
  endfunction

  task automatic read_results(output logic [159:0] r);
    logic [31:0] v;
    for (int k = 0; k < 5; k++) begin
      rd(3'(3 + k), v);
      r[159 - 32*k -: 32] = v;
    end
  endtask

  task automatic run(input logic [63:0] d, input logic [7:0] syn);
    wr(3'd1, d[31:0]);
    wr(3'd2, d[63:32]);
    wr(3'd0, {8'h80, syn, 16'h0008});
    wr(3'd0, {8'h80, syn, 16'h000A});
    repeat (RUN) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [159:0] r, e, keep;
    logic [31:0] v;
    logic [63:0] pats [3];
    int n;
    n = 0;
    for (int k = 0; k < 256; k++) begin
      if (($countones(8'(k)) % 2 == 1) && ($countones(8'(k)) >= 3) && n < 64) begin
        bcol[n] = 8'(k); n++;
      end
    end
    pats[0] = 64'hAAAAAAAA_55555555;
    pats[1] = 64'h0;
    pats[2] = 64'h01234567_89ABCDEF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 8; a++) chk_reg("R1", 3'(a), 32'h0);

    // R2 locked: ctrl and operand writes ignored
    wr(3'd0, 32'h80FF000A);
    chk_reg("R2", 3'd0, 32'h0);
    wr(3'd1, 32'h12345678);
    chk_reg("R2", 3'd1, 32'h0);
    wr(3'd0, 32'hF9F99999);
    chk_reg("R2", 3'd0, 32'h80000000);

    // R3 field layout, unused bits read 0
    wr(3'd0, 32'hFF3CFFF4);
    chk_reg("R3", 3'd0, 32'h803C0000);

    // R10 worked example, R5 timing
    wr(3'd1, 32'h55555555);
    wr(3'd2, 32'hAAAAAAAA);
    wr(3'd0, 32'h80FF0000);
    wr(3'd0, 32'h80FF0008);
    wr(3'd0, 32'h80FF000A);
    chk_reg("R5", 3'd0, 32'h80FF000A);
    repeat (RUN) @(negedge clk);
    chk_reg("R5", 3'd0, 32'h80FF000B);
    read_results(r);
    check("R10", r[159:128], 32'h55555555);
    check("R10", r[127:96],  32'hAAAAAAAA);
    check("R10", r[95:64],   32'h55555555);
    check("R10", r[63:32],   32'hAAAAAAAA);
    check("R10", r[31:0],    32'h00FF00FF);

    // R6 rewriting start while set: no new run, done stays
    wr(3'd0, 32'h80FF000A);
    chk_reg("R6", 3'd0, 32'h80FF000B);

    // R7 R8 R9 exhaustive syndrome sweep
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 256; s++) begin
        run(pats[p], 8'(s));
        rd(3'd0, v);
        check("R5", v, {8'h80, 8'(s), 16'h000B});
        read_results(r);
        e = expect_res(pats[p], 8'(s));
        if (8'(s) == 8'hFF)                  check("R7", r[31:0], e[31:0]);
        else if (r[31:0] !== e[31:0])        check("R9", r[31:0], e[31:0]);
        if (r !== e) begin
          fails++;
          $display("FAIL R8: syn %h got %h expected %h", 8'(s), r, e);
        end
        tests++;
      end
    end
    keep = expect_res(pats[2], 8'hFF);

    // R6 R11 cancel mid-run keeps old results
    wr(3'd0, 32'h80120008);
    wr(3'd0, 32'h8012000A);
    wr(3'd0, 32'h80120008);
    repeat (RUN + 2) @(negedge clk);
    chk_reg("R6", 3'd0, 32'h80120008);
    read_results(r);
    tests++;
    if (r !== keep) begin fails++; $display("FAIL R11: got %h expected %h", r, keep); end

    // R5 operand snapshot: change data after start
    wr(3'd1, 32'hCAFE0001);
    wr(3'd2, 32'h0000BEEF);
    wr(3'd0, 32'h80FF000A);
    wr(3'd1, 32'h11111111);
    repeat (RUN) @(negedge clk);
    read_results(r);
    e = expect_res(64'h0000BEEF_CAFE0001, 8'hFF);
    tests++;
    if (r !== e) begin fails++; $display("FAIL R5: got %h expected %h", r, e); end

    // R4 exit clears control; R11 results kept
    wr(3'd0, 32'h0);
    chk_reg("R4", 3'd0, 32'h0);
    read_results(r);
    tests++;
    if (r !== e) begin fails++; $display("FAIL R11: got %h expected %h", r, e); end
    wr(3'd2, 32'h5A5A5A5A);
    chk_reg("R2", 3'd2, 32'h0000BEEF);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule